// File: doc/BRIEF.md
# ADC Pre-Trigger Sequencer Channel

This block is one channel of a delay-driven trigger generator that starts ADC conversions. It has a parameterised number of pre-trigger lanes. Each lane has its own delay compare, a delay bypass, a chained (back-to-back) start mode and a conversion lock. An external free-running counter and per-lane delay values are supplied from outside. After a trigger input event, each lane issues a one-cycle pre-trigger pulse: when the counter reaches that lane's delay, after a fixed two-cycle latency in bypass mode, or two cycles after an acknowledgment in chained mode. The channel trigger output goes with a pre-trigger only if no conversion started earlier is still outstanding.

Every lane runs a small state machine with four states. LN_IDLE waits for a start. LN_ARMED waits for the counter to equal the lane's delay. LN_WAIT_A and LN_WAIT_B are the two fixed latency stages. The transitions are as follows. LN_IDLE goes to LN_ARMED on a trigger event in delay mode. LN_IDLE goes to LN_WAIT_A on a trigger event in bypass mode, or on an acknowledgment in chained mode. LN_WAIT_A goes to LN_WAIT_B. LN_WAIT_B goes to LN_IDLE and fires. LN_ARMED goes to LN_IDLE and fires when the counter matches. Any state goes to LN_IDLE when the lane or the block is disabled. A pre-trigger sets the lane's lock. If a pre-trigger fires while any lock is held, a sticky sequence error is recorded. An idle-delay compare sets a sticky flag, which signals either an interrupt or a DMA request.

Top module: `adc_pretrig_seq`

## Requirements
- R1: In bypass mode (lane_byp[i]=1, lane_chain[i]=0), a trigger event sampled at clock edge t gives pre_trig[i] high for exactly the one cycle after edge t+2.
- R2: In chained mode (lane_chain[i]=1), trigger events and the lane's delay value have no effect. An ack_in[i] sampled at edge t gives pre_trig[i] high for the one cycle after edge t+2.
- R3: In delay mode (both mode bits 0), after a trigger event the lane waits in LN_ARMED. It pulses pre_trig[i] for one cycle, in the cycle after the counter sample that equals lane_dly[i*CNT_W +: CNT_W]. The pulse never lasts two consecutive cycles.
- R4: A pre-trigger makes the lane's lock active.
- R5: A lock is released by a rising edge of conv_done[i]. A level that stays high releases it only once.
- R6: Clearing lane_en[i] or blk_en releases the lane's lock and returns the lane to LN_IDLE, which cancels any pending pre-trigger.
- R7: chan_trig is a one-cycle pulse issued together with any pre-trigger, only when no lock was active in the cycle before. Otherwise it is suppressed.
- R8: A pre-trigger on lane i while any lock is active sets seq_err[i]. The flag stays set until a one is written to seq_err_clr[i]. A new set wins over a clear in the same cycle.
- R9: seq_err_irq is high exactly while seq_err_ie is high and any seq_err bit is set.
- R10: While blk_en is high, cnt_val equal to idle_dly sets idle_flag, which stays set until a one is written to idle_clr. With blk_en low, the compare has no effect.
- R11: idle_irq is high only while idle_flag, idle_ie are set and dma_mode is clear.
- R12: When dma_mode is set, the idle compare also sets dma_req, which stays high until dma_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_en | input | 1 | Whole-block enable |
| trig_evt | input | 1 | Trigger input event |
| cnt_val | input | CNT_W | Free-running counter value |
| lane_en | input | LANES | Per-lane pre-trigger enable |
| lane_byp | input | LANES | Per-lane delay bypass |
| lane_chain | input | LANES | Per-lane back-to-back mode |
| lane_dly | input | LANES*CNT_W | Per-lane delay, lane i at [i*CNT_W +: CNT_W] |
| conv_done | input | LANES | Per-lane conversion-complete level |
| ack_in | input | LANES | Per-lane chaining acknowledgment |
| seq_err_clr | input | LANES | Write-one-to-clear of error flags |
| seq_err_ie | input | 1 | Sequence error interrupt enable |
| idle_dly | input | CNT_W | Idle-delay compare value |
| idle_clr | input | 1 | Write-one-to-clear of the idle flag |
| idle_ie | input | 1 | Idle interrupt enable |
| dma_mode | input | 1 | Route the idle event to a DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| pre_trig | output | LANES | Per-lane pre-trigger pulses |
| chan_trig | output | 1 | Channel trigger pulse |
| seq_err | output | LANES | Sticky sequence error flags |
| seq_err_irq | output | 1 | Sequence error interrupt |
| idle_flag | output | 1 | Sticky idle-delay flag |
| idle_irq | output | 1 | Idle-delay interrupt |
| dma_req | output | 1 | Idle-delay DMA request |

## Verification
The latency assertions for bypass and chained lanes assume that a lane's enables and mode bits stay unchanged from its start until its pulse. They also assume that mode bits are changed only while the lane is idle. The directed stimulus meets this by setting the configuration before each scenario. It changes enables only where the scenario is meant to cancel or release something. The lock-release property assumes that conv_done is a level the bench holds for at least one cycle. The stimulus drives it from the falling edge.

// File: rtl/trig_seq_pkg.sv
`timescale 1ns/1ps
package trig_seq_pkg;

    typedef enum logic [1:0] {
        LN_IDLE   = 2'd0,
        LN_ARMED  = 2'd1,
        LN_WAIT_A = 2'd2,
        LN_WAIT_B = 2'd3
    } lane_state_e;

endpackage

// File: rtl/trig_seq_lane.sv
`timescale 1ns/1ps
module trig_seq_lane
    import trig_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_en,
    input  logic             lane_en,
    input  logic             use_bypass,
    input  logic             use_chain,
    input  logic             trig_evt,
    input  logic             chain_ack,
    input  logic             conv_done,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] dly_val,
    output logic             fire_o,
    output logic             pretrig_o,
    output logic             lock_o
);

    lane_state_e st_q, st_d;
    logic        lane_ok;
    logic        dly_hit;
    logic        done_d;
    logic        done_rise;
    logic        pretrig_q;
    logic        lock_q;

    assign lane_ok   = blk_en && lane_en;
    assign dly_hit   = (cnt_val == dly_val);
    assign done_rise = conv_done && !done_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_IDLE: begin
                if (use_chain) begin
                    if (chain_ack) st_d = LN_WAIT_A;
                end else if (trig_evt) begin
                    st_d = use_bypass ? LN_WAIT_A : LN_ARMED;
                end
            end
            LN_ARMED:  if (dly_hit) st_d = LN_IDLE;
            LN_WAIT_A: st_d = LN_WAIT_B;
            LN_WAIT_B: st_d = LN_IDLE;
            default:   st_d = LN_IDLE;
        endcase
        if (!lane_ok) st_d = LN_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_IDLE;
        else        st_q <= st_d;
    end

    assign fire_o = lane_ok &&
                    ((st_q == LN_WAIT_B) || ((st_q == LN_ARMED) && dly_hit));

    // outputs: pulse, edge history, lock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pretrig_q <= 1'b0;
            done_d    <= 1'b0;
            lock_q    <= 1'b0;
        end else begin
            pretrig_q <= fire_o;
            done_d    <= conv_done;
            if (!lane_ok)       lock_q <= 1'b0;
            else if (fire_o)    lock_q <= 1'b1;
            else if (done_rise) lock_q <= 1'b0;
        end
    end

    assign pretrig_o = pretrig_q;
    assign lock_o    = lock_q;

    AST_BYPASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_IDLE && lane_ok && trig_evt && use_bypass && !use_chain) |=> ##2 pretrig_o); // R1
    AST_CHAIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_IDLE && lane_ok && use_chain && chain_ack) |=> ##2 pretrig_o); // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pretrig_o |=> !pretrig_o); // R3
    AST_LOCK_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        pretrig_o |-> lock_o); // R4
    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !fire_o && conv_done && !done_d) |=> !lock_o); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_ok |=> (!lock_o && !pretrig_o && st_q == LN_IDLE)); // R6

endmodule

// File: rtl/trig_seq_chan.sv
`timescale 1ns/1ps
module trig_seq_chan #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] fire,
    input  logic [LANES-1:0] lock,
    input  logic [LANES-1:0] err_clr,
    input  logic             err_ie,
    output logic [LANES-1:0] err_q,
    output logic             err_irq,
    output logic             trig_o
);

    logic any_lock;
    logic any_fire;
    logic trig_q;

    assign any_lock = |lock;
    assign any_fire = |fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= any_fire && !any_lock;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_err
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    err_q[i] <= 1'b0;
            else if (fire[i] && any_lock)  err_q[i] <= 1'b1;
            else if (err_clr[i])           err_q[i] <= 1'b0;
        end
    end

    assign err_irq = err_ie && (|err_q);
    assign trig_o  = trig_q;

    AST_TRIG_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !$past(any_lock)); // R7
    AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o); // R7
    AST_ERR_ON_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fire && any_lock) |=> (|err_q)); // R8
    AST_ERR_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_ie |-> !err_irq); // R9

endmodule

// File: rtl/trig_seq_idle.sv
`timescale 1ns/1ps
module trig_seq_idle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] idle_dly,
    input  logic             idle_clr,
    input  logic             idle_ie,
    input  logic             dma_mode,
    input  logic             dma_ack,
    output logic             flag_o,
    output logic             irq_o,
    output logic             dreq_o
);

    logic hit;
    logic flag_q;
    logic dreq_q;

    assign hit = blk_en && (cnt_val == idle_dly);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            dreq_q <= 1'b0;
        end else begin
            if (hit)           flag_q <= 1'b1;
            else if (idle_clr) flag_q <= 1'b0;
            if (hit && dma_mode) dreq_q <= 1'b1;
            else if (dma_ack)    dreq_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && idle_ie && !dma_mode;
    assign dreq_o = dreq_q;

    AST_IDLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && cnt_val == idle_dly) |=> flag_o); // R10
    AST_IRQ_NOT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!dma_mode && flag_o)); // R11
    AST_DREQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_o && dma_ack && !(hit && dma_mode)) |=> !dreq_o); // R12

endmodule

// File: rtl/adc_pretrig_seq.sv
`timescale 1ns/1ps
module adc_pretrig_seq #(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_en,
    input  logic                   trig_evt,
    input  logic [CNT_W-1:0]       cnt_val,
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES-1:0]       lane_byp,
    input  logic [LANES-1:0]       lane_chain,
    input  logic [LANES*CNT_W-1:0] lane_dly,
    input  logic [LANES-1:0]       conv_done,
    input  logic [LANES-1:0]       ack_in,
    input  logic [LANES-1:0]       seq_err_clr,
    input  logic                   seq_err_ie,
    input  logic [CNT_W-1:0]       idle_dly,
    input  logic                   idle_clr,
    input  logic                   idle_ie,
    input  logic                   dma_mode,
    input  logic                   dma_ack,
    output logic [LANES-1:0]       pre_trig,
    output logic                   chan_trig,
    output logic [LANES-1:0]       seq_err,
    output logic                   seq_err_irq,
    output logic                   idle_flag,
    output logic                   idle_irq,
    output logic                   dma_req
);

    logic [LANES-1:0] fire_w;
    logic [LANES-1:0] lock_w;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        trig_seq_lane #(.CNT_W(CNT_W)) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .blk_en     (blk_en),
            .lane_en    (lane_en[i]),
            .use_bypass (lane_byp[i]),
            .use_chain  (lane_chain[i]),
            .trig_evt   (trig_evt),
            .chain_ack  (ack_in[i]),
            .conv_done  (conv_done[i]),
            .cnt_val    (cnt_val),
            .dly_val    (lane_dly[i*CNT_W +: CNT_W]),
            .fire_o     (fire_w[i]),
            .pretrig_o  (pre_trig[i]),
            .lock_o     (lock_w[i])
        );
    end

    trig_seq_chan #(.LANES(LANES)) chan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire_w),
        .lock    (lock_w),
        .err_clr (seq_err_clr),
        .err_ie  (seq_err_ie),
        .err_q   (seq_err),
        .err_irq (seq_err_irq),
        .trig_o  (chan_trig)
    );

    trig_seq_idle #(.CNT_W(CNT_W)) idle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (blk_en),
        .cnt_val  (cnt_val),
        .idle_dly (idle_dly),
        .idle_clr (idle_clr),
        .idle_ie  (idle_ie),
        .dma_mode (dma_mode),
        .dma_ack  (dma_ack),
        .flag_o   (idle_flag),
        .irq_o    (idle_irq),
        .dreq_o   (dma_req)
    );

    AST_PRETRIG_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_trig |-> (|pre_trig)); // R7

endmodule

// File: tb/adc_pretrig_seq_tb_top.sv
`timescale 1ns/1ps
module adc_pretrig_seq_tb_top;

    localparam int LANES = 4;
    localparam int CNT_W = 16;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   blk_en, trig_evt, seq_err_ie, idle_clr, idle_ie, dma_mode, dma_ack;
    logic [CNT_W-1:0]       cnt_val, idle_dly;
    logic [LANES-1:0]       lane_en, lane_byp, lane_chain, conv_done, ack_in, seq_err_clr;
    logic [LANES*CNT_W-1:0] lane_dly;
    logic [LANES-1:0]       pre_trig, seq_err;
    logic                   chan_trig, seq_err_irq, idle_flag, idle_irq, dma_req;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    adc_pretrig_seq #(.LANES(LANES), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .trig_evt(trig_evt), .cnt_val(cnt_val),
        .lane_en(lane_en), .lane_byp(lane_byp), .lane_chain(lane_chain), .lane_dly(lane_dly),
        .conv_done(conv_done), .ack_in(ack_in), .seq_err_clr(seq_err_clr),
        .seq_err_ie(seq_err_ie), .idle_dly(idle_dly), .idle_clr(idle_clr), .idle_ie(idle_ie),
        .dma_mode(dma_mode), .dma_ack(dma_ack), .pre_trig(pre_trig), .chan_trig(chan_trig),
        .seq_err(seq_err), .seq_err_irq(seq_err_irq), .idle_flag(idle_flag),
        .idle_irq(idle_irq), .dma_req(dma_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // disable all lanes for a cycle (clears locks and state), clear errors, then enable mask
    task automatic prep(input logic [LANES-1:0] mask);
        lane_en = '0; lane_byp = '0; lane_chain = '0;
        trig_evt = 1'b0; ack_in = '0; conv_done = '0; seq_err_clr = '1;
        step();
        seq_err_clr = '0;
        lane_en = mask;
    endtask

    // trigger pulse sampled at next edge t; returns at the falling edge after t+2
    task automatic pulse_trig();
        trig_evt = 1'b1;
        step();
        trig_evt = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        check("R7", "chan_trig after reset", 32'(chan_trig), 32'd0);
        check("R8", "seq_err after reset", 32'(seq_err), 32'd0);
        check("R12", "dma_req after reset", 32'(dma_req), 32'd0);
        check("R10", "idle_flag after reset", 32'(idle_flag), 32'd0);
    endtask

    task automatic t_bypass();   // R1 R4 R7 R8 R9
        prep(4'b0001);
        lane_byp = 4'b0001;
        trig_evt = 1'b1;
        step();
        trig_evt = 1'b0;
        check("R1", "pre_trig t+1", 32'(pre_trig), 32'd0);
        step();
        check("R1", "pre_trig t+2", 32'(pre_trig), 32'd0);
        step();
        check("R1", "pre_trig t+3", 32'(pre_trig), 32'h1);
        check("R7", "chan_trig unlocked", 32'(chan_trig), 32'd1);
        step();
        check("R1", "pre_trig one cycle", 32'(pre_trig), 32'd0);
        check("R7", "chan_trig one cycle", 32'(chan_trig), 32'd0);
        // lane is now locked (R4): next start is suppressed and errors
        seq_err_ie = 1'b0;
        pulse_trig();
        check("R4", "pre_trig while locked", 32'(pre_trig), 32'h1);
        check("R7", "chan_trig suppressed", 32'(chan_trig), 32'd0);
        check("R8", "seq_err set", 32'(seq_err), 32'h1);
        check("R9", "irq disabled", 32'(seq_err_irq), 32'd0);
        seq_err_ie = 1'b1;
        step();
        check("R9", "irq enabled", 32'(seq_err_irq), 32'd1);
        check("R8", "seq_err sticky", 32'(seq_err), 32'h1);
        seq_err_clr = 4'b0001;
        step();
        seq_err_clr = '0;
        check("R8", "seq_err cleared", 32'(seq_err), 32'd0);
        check("R9", "irq cleared", 32'(seq_err_irq), 32'd0);
        seq_err_ie = 1'b0;
    endtask

    task automatic t_delay();    // R3
        prep(4'b0010);
        lane_dly[1*CNT_W +: CNT_W] = 16'd37;
        cnt_val = 16'd10;
        trig_evt = 1'b1;
        step();
        trig_evt = 1'b0;
        cnt_val = 16'd36;
        check("R3", "no pulse before match", 32'(pre_trig), 32'd0);
        step();
        cnt_val = 16'd37;
        check("R3", "no pulse at 36", 32'(pre_trig), 32'd0);
        step();
        cnt_val = 16'd38;
        check("R3", "pulse after match", 32'(pre_trig), 32'h2);
        check("R7", "chan_trig with delay lane", 32'(chan_trig), 32'd1);
        step();
        check("R3", "pulse ends", 32'(pre_trig), 32'd0);
        lane_dly[1*CNT_W +: CNT_W] = 16'd1000;
    endtask

    task automatic t_chain();    // R2
        prep(4'b0100);
        lane_chain = 4'b0100;
        cnt_val = 16'd55;
        lane_dly[2*CNT_W +: CNT_W] = 16'd55;
        trig_evt = 1'b1;
        step();
        trig_evt = 1'b0;
        check("R2", "trigger ignored t+1", 32'(pre_trig), 32'd0);
        step();
        check("R2", "trigger ignored t+2", 32'(pre_trig), 32'd0);
        step();
        check("R2", "trigger/delay ignored t+3", 32'(pre_trig), 32'd0);
        ack_in = 4'b0100;
        step();
        ack_in = '0;
        check("R2", "ack t+1", 32'(pre_trig), 32'd0);
        step();
        check("R2", "ack t+2", 32'(pre_trig), 32'd0);
        step();
        check("R2", "ack t+3", 32'(pre_trig), 32'h4);
        check("R7", "chan_trig chained", 32'(chan_trig), 32'd1);
        lane_dly[2*CNT_W +: CNT_W] = 16'd1000;
        cnt_val = 16'd100;
    endtask

    task automatic t_release();  // R5
        prep(4'b0001);
        lane_byp = 4'b0001;
        pulse_trig();
        check("R5", "first start", 32'(chan_trig), 32'd1);
        step();
        conv_done = 4'b0001;
        step();
        pulse_trig();
        check("R5", "start after release", 32'(chan_trig), 32'd1);
        check("R5", "no error after release", 32'(seq_err), 32'd0);
        step();
        pulse_trig();
        check("R5", "held level no second release", 32'(chan_trig), 32'd0);
        check("R5", "error with held level", 32'(seq_err), 32'h1);
        conv_done = '0;
    endtask

    task automatic t_disable();  // R6
        prep(4'b0001);
        lane_byp = 4'b0001;
        pulse_trig();
        step();
        lane_en = '0;
        step();
        lane_en = 4'b0001;
        pulse_trig();
        check("R6", "lane disable releases lock", 32'(chan_trig), 32'd1);
        check("R6", "no error after lane disable", 32'(seq_err), 32'd0);
        step();
        blk_en = 1'b0;
        step();
        blk_en = 1'b1;
        pulse_trig();
        check("R6", "block disable releases lock", 32'(chan_trig), 32'd1);
        check("R6", "no error after block disable", 32'(seq_err), 32'd0);
        prep(4'b0010);
        lane_dly[1*CNT_W +: CNT_W] = 16'd20;
        cnt_val = 16'd5;
        trig_evt = 1'b1;
        step();
        trig_evt = 1'b0;
        lane_en = '0;
        step();
        lane_en = 4'b0010;
        cnt_val = 16'd20;
        step();
        check("R6", "pending cancelled a", 32'(pre_trig), 32'd0);
        step();
        check("R6", "pending cancelled b", 32'(pre_trig), 32'd0);
        cnt_val = 16'd100;
        lane_dly[1*CNT_W +: CNT_W] = 16'd1000;
    endtask

    task automatic t_idle();     // R10 R11 R12
        prep(4'b0000);
        idle_dly = 16'd200; idle_ie = 1'b1; dma_mode = 1'b0;
        blk_en = 1'b0;
        cnt_val = 16'd200;
        step();
        check("R10", "compare ignored when disabled", 32'(idle_flag), 32'd0);
        blk_en = 1'b1;
        step();
        cnt_val = 16'd201;
        check("R10", "flag set on match", 32'(idle_flag), 32'd1);
        check("R11", "irq in interrupt mode", 32'(idle_irq), 32'd1);
        check("R12", "no dma req in interrupt mode", 32'(dma_req), 32'd0);
        step();
        check("R10", "flag sticky", 32'(idle_flag), 32'd1);
        idle_clr = 1'b1;
        step();
        idle_clr = 1'b0;
        check("R10", "flag cleared", 32'(idle_flag), 32'd0);
        check("R11", "irq cleared", 32'(idle_irq), 32'd0);
        idle_ie = 1'b0;
        cnt_val = 16'd200;
        step();
        cnt_val = 16'd201;
        check("R11", "no irq when disabled", 32'(idle_irq), 32'd0);
        idle_clr = 1'b1;
        step();
        idle_clr = 1'b0;
        idle_ie = 1'b1;
        dma_mode = 1'b1;
        cnt_val = 16'd200;
        step();
        cnt_val = 16'd201;
        check("R12", "dma req raised", 32'(dma_req), 32'd1);
        check("R11", "no irq in dma mode", 32'(idle_irq), 32'd0);
        step();
        check("R12", "dma req held", 32'(dma_req), 32'd1);
        dma_ack = 1'b1;
        step();
        dma_ack = 1'b0;
        check("R12", "dma req dropped", 32'(dma_req), 32'd0);
        check("R10", "flag kept after ack", 32'(idle_flag), 32'd1);
        cnt_val = 16'd100;
    endtask

    initial begin
        rst_n = 1'b0; blk_en = 1'b0; trig_evt = 1'b0; cnt_val = 16'd100;
        lane_en = '0; lane_byp = '0; lane_chain = '0; conv_done = '0; ack_in = '0;
        seq_err_clr = '0; seq_err_ie = 1'b0; idle_dly = 16'hFFFF; idle_clr = 1'b0;
        idle_ie = 1'b0; dma_mode = 1'b0; dma_ack = 1'b0;
        for (int i = 0; i < LANES; i++) lane_dly[i*CNT_W +: CNT_W] = 16'd1000;
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        blk_en = 1'b1;
        t_bypass();
        t_delay();
        t_chain();
        t_release();
        t_disable();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule